// File: doc/BRIEF.md
# Glitch-Free Clock Output Router

This block places internally generated clocks on two output pins: a main clock output and an auxiliary output. Each output has its own enable. The main output picks one of two derived clocks. The auxiliary output has a 2-bit source code that selects one of four things: either derived clock, the raw reference clock, or a level that shows whether the loop is out of lock. While the loop reports that it is not locked, every clock-carrying output is turned off automatically. A disabled output sits at a static low.

Each derived-clock path has a gate. The gate samples its request through a short synchroniser chain in the clock's own domain and changes state only on a falling edge. Because of this, enabling, disabling, automatic lock-loss shutoff and handover between the two derived clocks never cut a high phase short and never insert a narrow pulse. Handover is break-before-make: the old gate closes, and only then does the new gate open, so the output rests low in between. Selecting the reference clock or the lock-status level is a direct multiplexer switch. That switch may produce a partial period, and this is accepted.

Top module: `clk_out_router`

## Requirements
- R1: With `main_en`=1 and `pll_locked`=1, `main_clk_out` carries `clk_deriv_a` when `main_sel`=0 and `clk_deriv_b` when `main_sel`=1, once the handover latency has elapsed.
- R2: When its enable is 0, or when `pll_locked`=0, each clock-carrying output settles to a static low.
- R3: On any output path gated by the derived-clock logic, no high phase is shorter than a full source half period and no low phase is shorter than the faster source's half period. This holds across enable changes, lock loss and regain, and select changes between the derived clocks.
- R4: Auxiliary code 2'b00 routes `clk_deriv_a` and code 2'b10 routes `clk_deriv_b`, gated by `aux_en` and `pll_locked`.
- R5: Auxiliary code 2'b01 routes `clk_ref` while `aux_en`=1 and `pll_locked`=1, and gives a static low otherwise.
- R6: Auxiliary code 2'b11 drives the level (`aux_en` AND NOT `pll_locked`) straight to `aux_clk_out`, with no clock gating.
- R7: The two gates of one derived-clock path are never open at the same time. During handover the output stays low until the new gate opens.
- R8: A gate samples its request on SYNC_STAGES (default 2) rising edges of its own clock and changes on the falling edge that follows. Enabling a stopped output therefore gives the first output rise on the (SYNC_STAGES+1)-th source rising edge after the request. Disabling lets exactly SYNC_STAGES more high phases through.
- R9: `rst` is synchronous and active high in every clock domain. While it is held, both outputs are low and all gate and synchroniser state is cleared, whatever the enables say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled in each clock domain |
| clk_deriv_a | input | 1 | First derived clock |
| clk_deriv_b | input | 1 | Second derived clock |
| clk_ref | input | 1 | Raw reference clock |
| pll_locked | input | 1 | Lock status, 1 = locked |
| main_en | input | 1 | Main output enable |
| main_sel | input | 1 | Main source: 0 = derived A, 1 = derived B |
| aux_en | input | 1 | Auxiliary output enable |
| aux_sel | input | 2 | Auxiliary source: 00 A, 10 B, 01 reference, 11 unlock level |
| main_clk_out | output | 1 | Main clock output |
| aux_clk_out | output | 1 | Auxiliary clock output |

## Verification
A gate reacts on the falling edge after the second rising edge of its own clock. The bench times one enable and one disable from a point just after a falling edge of `clk_deriv_a`. It expects the first output rise 23.75 ns later, and exactly two more high phases after a disable. For every other stimulus, a full handover (close, then open, across both clock domains) takes well under 100 ns. The bench therefore waits 400 ns before it classifies an output by the width of its high phase or by its static level. Edge monitors measure every high and low phase on the gated paths continuously. This lets them catch partial periods during the transitions themselves, not only after they settle.

// File: rtl/cor_pkg.sv
package cor_pkg;

    localparam int SYNC_STAGES_DEFAULT = 2;

    typedef enum logic [1:0] {
        AUX_DERIVED_A = 2'b00,
        AUX_REF       = 2'b01,
        AUX_DERIVED_B = 2'b10,
        AUX_UNLOCK    = 2'b11
    } aux_src_e;

    typedef struct packed {
        logic en;
        logic sel;
    } route_req_t;

    function automatic logic aux_is_derived(aux_src_e s);
        return (s == AUX_DERIVED_A) || (s == AUX_DERIVED_B);
    endfunction

    function automatic logic aux_pick_b(aux_src_e s);
        return s == AUX_DERIVED_B;
    endfunction

endpackage

// File: rtl/cor_sync.sv
module cor_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cor_clk_gate.sv
module cor_clk_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic want,
    output logic gate_on
);
    logic want_sync;

    cor_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (want),
        .q   (want_sync)
    );

    // Gate moves only while the clock is low.
    always_ff @(negedge clk) begin
        if (rst) gate_on <= 1'b0;
        else     gate_on <= want_sync;
    end

    // R8: opening follows a request seen SYNC_STAGES rising edges earlier
    assert_open_after_req_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_on) |-> $past(want, SYNC_STAGES));

    // R8: closing follows a dropped request seen SYNC_STAGES rising edges earlier
    assert_close_after_drop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_on) |-> !$past(want, SYNC_STAGES));

    // R9: reset held across a falling edge leaves the gate shut
    assert_reset_clear_R9: assert property (@(posedge clk)
        (rst && $past(rst)) |-> !gate_on);
endmodule

// File: rtl/cor_glitchfree_mux.sv
module cor_glitchfree_mux
    import cor_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       rst,
    input  logic       clk_a,
    input  logic       clk_b,
    input  route_req_t req,
    output logic       clk_out
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] gate_on;
    logic [NUM_SRC-1:0] want;

    assign src_clk = {clk_b, clk_a};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
        // break-before-make: a leg asks only once the other leg is shut
        assign want[i] = req.en && (req.sel == 1'(i)) && !gate_on[NUM_SRC-1-i];

        cor_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk     (src_clk[i]),
            .rst     (rst),
            .want    (want[i]),
            .gate_on (gate_on[i])
        );
    end

    assign clk_out = |(src_clk & gate_on);

    // R7: never two legs open together
    assert_one_source_R7: assert property (@(posedge clk_a) disable iff (rst)
        !(gate_on[0] && gate_on[1]));
endmodule

// File: rtl/clk_out_router.sv
module clk_out_router
    import cor_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEFAULT
) (
    input  logic       rst,
    input  logic       clk_deriv_a,
    input  logic       clk_deriv_b,
    input  logic       clk_ref,
    input  logic       pll_locked,
    input  logic       main_en,
    input  logic       main_sel,
    input  logic       aux_en,
    input  logic [1:0] aux_sel,
    output logic       main_clk_out,
    output logic       aux_clk_out
);
    aux_src_e   aux_src;
    route_req_t main_req;
    route_req_t aux_req;
    logic       aux_mux_clk;
    logic       ref_want;
    logic       ref_gate_on;

    assign aux_src  = aux_src_e'(aux_sel);
    assign main_req = '{en: main_en && pll_locked, sel: main_sel};
    assign aux_req  = '{en: aux_en && pll_locked && aux_is_derived(aux_src),
                        sel: aux_pick_b(aux_src)};
    assign ref_want = aux_en && pll_locked && (aux_src == AUX_REF);

    cor_glitchfree_mux #(.SYNC_STAGES(SYNC_STAGES)) u_main_mux (
        .rst     (rst),
        .clk_a   (clk_deriv_a),
        .clk_b   (clk_deriv_b),
        .req     (main_req),
        .clk_out (main_clk_out)
    );

    cor_glitchfree_mux #(.SYNC_STAGES(SYNC_STAGES)) u_aux_mux (
        .rst     (rst),
        .clk_a   (clk_deriv_a),
        .clk_b   (clk_deriv_b),
        .req     (aux_req),
        .clk_out (aux_mux_clk)
    );

    cor_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_ref_gate (
        .clk     (clk_ref),
        .rst     (rst),
        .want    (ref_want),
        .gate_on (ref_gate_on)
    );

    // Direct final selection; only the derived pair is glitch-free here.
    always_comb begin
        unique case (aux_src)
            AUX_REF:    aux_clk_out = clk_ref && ref_gate_on;
            AUX_UNLOCK: aux_clk_out = aux_en && !pll_locked;
            default:    aux_clk_out = aux_mux_clk;
        endcase
    end
endmodule

// File: tb/clk_out_router_bench.sv
`timescale 1ns/1ps
module clk_out_router_bench;
    localparam int K_LOW = 0, K_HIGH = 1, K_A = 2, K_B = 3, K_REF = 4, K_BAD = 5;

    logic rst = 1'b1;
    logic clk_deriv_a = 1'b0, clk_deriv_b = 1'b0, clk_ref = 1'b0;
    logic pll_locked = 1'b0, main_en = 1'b0, main_sel = 1'b0, aux_en = 1'b0;
    logic [1:0] aux_sel = 2'b00;
    logic main_clk_out, aux_clk_out;

    int n_checks = 0, n_fail = 0, cyc = 0;

    always #5   clk_deriv_a = ~clk_deriv_a;   // 100 MHz
    always #7   clk_deriv_b = ~clk_deriv_b;
    always #8.5 clk_ref     = ~clk_ref;

    clk_out_router u_clk_out_router (
        .rst, .clk_deriv_a, .clk_deriv_b, .clk_ref, .pll_locked,
        .main_en, .main_sel, .aux_en, .aux_sel, .main_clk_out, .aux_clk_out
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int which);
        return (which == 0) ? main_clk_out : aux_clk_out;
    endfunction

    function automatic bit near(input real w, input real t);
        return (w > t - 0.3) && (w < t + 0.3);
    endfunction

    function automatic int exp_main(input logic en, input logic sel, input logic lk);
        if (!(en && lk)) return K_LOW;
        return sel ? K_B : K_A;
    endfunction

    function automatic int exp_aux(input logic en, input logic [1:0] s, input logic lk);
        case (s)
            2'b00:   return (en && lk) ? K_A : K_LOW;
            2'b10:   return (en && lk) ? K_B : K_LOW;
            2'b01:   return (en && lk) ? K_REF : K_LOW;
            default: return (en && !lk) ? K_HIGH : K_LOW;
        endcase
    endfunction

    // Classify an output over an 80 ns window by its first full high phase.
    task automatic observe(input int which, output int kind);
        logic prev, cur;
        real tr, tf;
        bit hr, hf;
        tr = 0.0; tf = 0.0; hr = 0; hf = 0;
        prev = sig(which); cur = prev;
        for (int k = 0; k < 160; k++) begin
            #0.5;
            cur = sig(which);
            if (cur && !prev && !hr) begin tr = $realtime; hr = 1; end
            else if (!cur && prev && hr && !hf) begin tf = $realtime; hf = 1; end
            prev = cur;
        end
        if (!hr)                 kind = cur ? K_HIGH : K_LOW;
        else if (!hf)            kind = K_BAD;
        else if (near(tf-tr,5.0)) kind = K_A;
        else if (near(tf-tr,7.0)) kind = K_B;
        else if (near(tf-tr,8.5)) kind = K_REF;
        else                     kind = K_BAD;
    endtask

    // Partial-period monitors
    bit  main_watch = 0, aux_watch = 0;
    bit  m_rv, m_fv, a_rv, a_fv;
    real m_rise, m_fall, a_rise, a_fall;
    int  runts_main = 0, runts_aux = 0;

    always @(posedge main_clk_out) if (main_watch) begin
        if (m_fv && ($realtime - m_fall) < 4.4) runts_main++;
        m_rise = $realtime; m_rv = 1;
    end
    always @(negedge main_clk_out) if (main_watch) begin
        if (m_rv && !near($realtime - m_rise, 5.0) && !near($realtime - m_rise, 7.0)) runts_main++;
        m_fall = $realtime; m_fv = 1;
    end
    always @(posedge aux_clk_out) if (aux_watch) begin
        if (a_fv && ($realtime - a_fall) < 4.4) runts_aux++;
        a_rise = $realtime; a_rv = 1;
    end
    always @(negedge aux_clk_out) if (aux_watch) begin
        if (a_rv && !near($realtime - a_rise, 5.0) && !near($realtime - a_rise, 7.0)) runts_aux++;
        a_fall = $realtime; a_fv = 1;
    end

    task automatic arm_aux();
        a_rv = 0; a_fv = 0; aux_watch = 1;
    endtask

    task automatic both(input string tag, input int em, input int ea);
        int k;
        observe(0, k); check({tag, " main"}, k, em);
        observe(1, k); check({tag, " aux"}, k, ea);
    endtask

    always @(posedge clk_deriv_a) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int k;
        int rises;
        real t0;
        logic prev;
        #0.25;
        // R9: enables asserted under reset have no effect
        main_en = 1; aux_en = 1; pll_locked = 1;
        #100;
        both("R9 reset", K_LOW, K_LOW);
        main_en = 0; aux_en = 0;
        #20; rst = 0; #60;
        m_rv = 0; m_fv = 0; main_watch = 1; arm_aux();
        both("R2 disabled after reset", K_LOW, K_LOW);

        main_en = 1; aux_en = 1; #400;
        both("R1 R4 source A", K_A, K_A);
        main_sel = 1; aux_sel = 2'b10; #400;
        both("R1 R4 R7 handover to B", K_B, K_B);
        main_sel = 0; aux_sel = 2'b00; #400;
        both("R1 R4 R7 handover to A", K_A, K_A);
        pll_locked = 0; #400;
        both("R2 unlocked auto off", K_LOW, K_LOW);
        pll_locked = 1; #400;
        both("R2 R3 relock", K_A, K_A);
        check("R3 main no partial period", runts_main, 0);
        check("R3 aux no partial period", runts_aux, 0);

        aux_watch = 0;
        aux_sel = 2'b11; #400;
        observe(1, k); check("R6 locked level low", k, K_LOW);
        pll_locked = 0; #400;
        observe(1, k); check("R6 unlock level high", k, K_HIGH);
        aux_en = 0; #400;
        observe(1, k); check("R6 level off when disabled", k, K_LOW);
        aux_en = 1; pll_locked = 1; aux_sel = 2'b01; #400;
        observe(1, k); check("R5 reference routed", k, K_REF);
        aux_en = 0; #400;
        observe(1, k); check("R5 reference disabled", k, K_LOW);
        aux_en = 1; aux_sel = 2'b00; #400;
        arm_aux();

        // R8 latency, stimulus 1.25 ns after a falling edge of derived A
        @(negedge clk_deriv_a); #1.25;
        main_en = 0;
        rises = 0; prev = main_clk_out;
        for (int j = 0; j < 120; j++) begin
            #0.5;
            if (main_clk_out && !prev) rises++;
            prev = main_clk_out;
        end
        check("R8 high phases after disable", rises, 2);
        @(negedge clk_deriv_a); #1.25;
        main_en = 1;
        t0 = $realtime; prev = main_clk_out;
        for (int j = 0; j < 120; j++) begin
            #0.5;
            if (main_clk_out && !prev) break;
            prev = main_clk_out;
        end
        check("R8 first rise delay ns", int'($realtime - t0), 24);
        #400;

        // Constrained random mix
        void'($urandom(32'h5EED_0C1C));
        for (int it = 0; it < 40; it++) begin
            logic [1:0] ns;
            ns = 2'($urandom_range(0, 3));
            if (ns[0] || aux_sel[0]) aux_watch = 0;
            main_en    = 1'($urandom_range(0, 3) != 0);
            main_sel   = 1'($urandom_range(0, 1));
            aux_en     = 1'($urandom_range(0, 3) != 0);
            pll_locked = 1'($urandom_range(0, 3) != 0);
            aux_sel    = ns;
            #400;
            both("R1 R2 R4 R5 R6 random", exp_main(main_en, main_sel, pll_locked),
                 exp_aux(aux_en, aux_sel, pll_locked));
            check("R3 R7 random main partial periods", runts_main, 0);
            check("R3 R7 random aux partial periods", runts_aux, 0);
            if (!aux_sel[0] && !aux_watch) arm_aux();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule